// File: doc/BRIEF.md
# PWM Switch-Rate Hop Controller

This block produces the switching-period tick for a PWM output stage. It counts enable pulses of the PWM master clock and emits one tick for each completed base period. A hop mode lowers the switching rate by a factor of 2.25 so that the switching harmonics move away from the frequency of a nearby AM receiver. In that mode an accumulator keeps four of every nine base periods, and the kept periods are spread evenly over the nine.

The hop setting can only take effect while the stage is powered down. A value written while the stage runs is held back and used at the next power-down. When power-down is released, the block waits for the rate converter to relock before it raises its ready flag and starts ticking. The wait ends when a relock-done indication arrives or when a programmable cycle timeout expires, whichever comes first. Any use of hop mode assumes that the master clock divided by 16 stays above the highest frequency the tuner receives.

Top module: `pwm_hop_ctrl`

## Requirements
- R1: During and after reset, `ready` is 0, `switchTick` is 0 and hop mode is off.
- R2: In normal mode, once `ready` is 1, `switchTick` pulses for one cycle on the cycle after every BASE_DIV-th clock edge at which `mclkEn` is 1. Edges at which `mclkEn` is 0 are not counted.
- R3: In hop mode, the base periods counted from the rise of `ready` fall into groups of nine. A tick is emitted only at the end of the 3rd, 5th, 7th and 9th base period of each group, which gives 4 ticks per 9 base periods.
- R4: `hopReq` is sampled into the hop setting only on clock edges at which `pwrDown` is 1. A change of `hopReq` while powered up has no effect on the tick rate until the next power-down.
- R5: On the cycle after an edge at which `pwrDown` is 1, `ready` and `switchTick` are both 0. The period count and the hop accumulator restart from zero.
- R6: After `pwrDown` falls, `ready` stays 0 until an edge at which `relockDone` is 1. `ready` rises on the cycle after that edge.
- R7: Without `relockDone`, `ready` rises on the cycle after the (RELOCK_TIMEOUT+1)-th edge at which `pwrDown` is 0, counted from power-down.
- R8: `switchTick` is never 1 while `ready` was 0 on the previous cycle. The first base period starts counting when `ready` rises.
- R9: Once `ready` is 1, it stays 1 until an edge at which `pwrDown` is 1.
- R10: `relockDone` has no effect while `pwrDown` is 1. The relock wait after the next power-up still runs in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclkEn | input | 1 | One pulse per PWM master clock period |
| pwrDown | input | 1 | Powers the modulator down when 1 |
| hopReq | input | 1 | Requested hop setting (1 = divide rate by 2.25) |
| relockDone | input | 1 | Rate converter reports that it has relocked |
| switchTick | output | 1 | One-cycle pulse per PWM switching period |
| ready | output | 1 | Output running after the relock wait |

## Verification
The bench builds the block with BASE_DIV = 4 and RELOCK_TIMEOUT = 20. With these values a full nine-period hop group takes only 36 enable pulses, and the timeout path ends within a few dozen cycles. Both the 3-5-7-9 tick pattern and the gap between timeout and relock-done can therefore be covered many times in a short run. The hop counts (HOP_NUM = 4, HOP_DEN = 9) stay at their defaults, so the 2.25 ratio is checked exactly as it is used.

// File: rtl/pwm_hop_pkg.sv
package pwm_hop_pkg;

  typedef enum logic [1:0] {
    PH_DOWN   = 2'd0,
    PH_RELOCK = 2'd1,
    PH_RUN    = 2'd2
  } phase_e;

  // Strobes from control to the rate datapath
  typedef struct packed {
    logic run;      // count periods and emit ticks
    logic hopMode;  // applied hop setting
  } ctrl_t;

endpackage

// File: rtl/pwm_hop_fsm.sv
module pwm_hop_fsm
  import pwm_hop_pkg::*;
#(
  parameter int RELOCK_TIMEOUT = 4096
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pwrDown,
  input  logic  hopReq,
  input  logic  relockDone,
  output ctrl_t ctrl,
  output logic  ready
);

  localparam int WW = (RELOCK_TIMEOUT > 1) ? $clog2(RELOCK_TIMEOUT) : 1;
  localparam logic [WW-1:0] WAIT_LAST = WW'(RELOCK_TIMEOUT - 1);

  phase_e        phase;
  logic [WW-1:0] waitCnt;
  logic          hopMode;
  logic          waitOver;

  assign waitOver = relockDone || (waitCnt == WAIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_DOWN;
      waitCnt <= '0;
    end else if (pwrDown) begin
      phase   <= PH_DOWN;
      waitCnt <= '0;
    end else begin
      unique case (phase)
        PH_DOWN: begin
          phase   <= PH_RELOCK;
          waitCnt <= '0;
        end
        PH_RELOCK: begin
          if (waitOver) phase <= PH_RUN;
          else          waitCnt <= waitCnt + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  // Hop setting only moves while powered down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hopMode <= 1'b0;
    else if (pwrDown) hopMode <= hopReq;
  end

  assign ready        = (phase == PH_RUN);
  assign ctrl.run     = ready && !pwrDown;
  assign ctrl.hopMode = hopMode;

endmodule

// File: rtl/pwm_hop_rate.sv
module pwm_hop_rate
  import pwm_hop_pkg::*;
#(
  parameter int BASE_DIV = 16,
  parameter int HOP_NUM  = 4,
  parameter int HOP_DEN  = 9
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mclkEn,
  input  ctrl_t ctrl,
  output logic  switchTick
);

  localparam int AW = $clog2(HOP_NUM + HOP_DEN) + 1;
  localparam logic [AW-1:0] STEP = AW'(HOP_NUM);
  localparam logic [AW-1:0] WRAP = AW'(HOP_DEN);

  logic          baseTick;
  logic [AW-1:0] acc;
  logic [AW-1:0] accSum;
  logic          carry;
  logic          keep;

  // Base period prescaler
  generate
    if (BASE_DIV > 1) begin : g_prescale
      localparam int CW = $clog2(BASE_DIV);
      localparam logic [CW-1:0] CNT_LAST = CW'(BASE_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (!ctrl.run) cnt <= '0;
        else if (mclkEn)    cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
      end

      assign baseTick = ctrl.run && mclkEn && (cnt == CNT_LAST);
    end else begin : g_direct
      assign baseTick = ctrl.run && mclkEn;
    end
  endgenerate

  // Fractional keep/drop accumulator
  assign accSum = acc + STEP;
  assign carry  = (accSum >= WRAP);
  assign keep   = !ctrl.hopMode || carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         acc <= '0;
    else if (!ctrl.run)                 acc <= '0;
    else if (baseTick && ctrl.hopMode)  acc <= carry ? accSum - WRAP : accSum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) switchTick <= 1'b0;
    else        switchTick <= baseTick && keep;
  end

endmodule

// File: rtl/pwm_hop_ctrl.sv
module pwm_hop_ctrl
  import pwm_hop_pkg::*;
#(
  parameter int BASE_DIV       = 16,
  parameter int HOP_NUM        = 4,
  parameter int HOP_DEN        = 9,
  parameter int RELOCK_TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclkEn,
  input  logic pwrDown,
  input  logic hopReq,
  input  logic relockDone,
  output logic switchTick,
  output logic ready
);

  ctrl_t ctrl;

  pwm_hop_fsm #(
    .RELOCK_TIMEOUT(RELOCK_TIMEOUT)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrDown   (pwrDown),
    .hopReq    (hopReq),
    .relockDone(relockDone),
    .ctrl      (ctrl),
    .ready     (ready)
  );

  pwm_hop_rate #(
    .BASE_DIV(BASE_DIV),
    .HOP_NUM (HOP_NUM),
    .HOP_DEN (HOP_DEN)
  ) i_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclkEn    (mclkEn),
    .ctrl      (ctrl),
    .switchTick(switchTick)
  );

endmodule

// File: rtl/pwm_hop_chk.sv
module pwm_hop_chk #(
  parameter int RELOCK_TIMEOUT = 4096
) (
  input logic clk,
  input logic rst_n,
  input logic pwrDown,
  input logic switchTick,
  input logic ready,
  input logic hopMode
);

  localparam int UW = $clog2(RELOCK_TIMEOUT + 2) + 1;
  localparam logic [UW-1:0] UP_SAT = UW'(RELOCK_TIMEOUT + 1);

  // Edges seen with power-down low since the last power-down edge
  logic [UW-1:0] upCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             upCnt <= '0;
    else if (pwrDown)       upCnt <= '0;
    else if (upCnt != UP_SAT) upCnt <= upCnt + 1'b1;
  end

  AST_INIT_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !ready && !switchTick); // R1
  AST_NO_TICK_DOWN: assert property (@(posedge clk) disable iff (!rst_n) pwrDown |=> !switchTick); // R5
  AST_DOWN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) pwrDown |=> !ready); // R5
  AST_HOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !pwrDown |=> $stable(hopMode)); // R4
  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (upCnt == UP_SAT) |-> ready); // R7
  AST_TICK_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n) switchTick |-> $past(ready)); // R8
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) ready && !pwrDown |=> ready); // R9

endmodule

bind pwm_hop_ctrl pwm_hop_chk #(
  .RELOCK_TIMEOUT(RELOCK_TIMEOUT)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwrDown   (pwrDown),
  .switchTick(switchTick),
  .ready     (ready),
  .hopMode   (ctrl.hopMode)
);

// File: tb/test_pwm_hop_ctrl.sv
module test_pwm_hop_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int B = 4;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclkEn = 1'b0;
  logic pwrDown = 1'b1;
  logic hopReq = 1'b0;
  logic relockDone = 1'b0;
  logic switchTick;
  logic ready;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  string phaseTag = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_hop_ctrl #(
    .BASE_DIV(B), .HOP_NUM(4), .HOP_DEN(9), .RELOCK_TIMEOUT(T)
  ) i_pwm_hop_ctrl (
    .clk(clk), .rst_n(rst_n), .mclkEn(mclkEn), .pwrDown(pwrDown),
    .hopReq(hopReq), .relockDone(relockDone),
    .switchTick(switchTick), .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 = off, 1 = waiting for relock, 2 = running
  int mState = 0, mWait = 0, mPer = 0, mBase = 0;
  bit mHop = 0, expTick = 0, expReady = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 0; mWait = 0; mPer = 0; mBase = 0; mHop = 0;
      expTick = 0; expReady = 0;
    end else begin
      bit live;
      live = (mState == 2) && !pwrDown;
      expTick = 0;
      if (!live) begin
        mPer = 0; mBase = 0;
      end else if (mclkEn) begin
        mPer++;
        if (mPer == B) begin
          mPer = 0;
          mBase = (mBase % 9) + 1;   // position in group of nine
          expTick = !mHop || (mBase == 3 || mBase == 5 || mBase == 7 || mBase == 9);
        end
      end
      if (pwrDown) mHop = hopReq;
      if (pwrDown) mState = 0;
      else if (mState == 0) begin mState = 1; mWait = 0; end
      else if (mState == 1) begin
        mWait++;
        if (relockDone || mWait == T) mState = 2;
      end
      expReady = (mState == 2);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(switchTick == expTick, {phaseTag, " tick"}, switchTick, expTick);
      check(ready == expReady, {phaseTag, " ready"}, ready, expReady);
    end
  end

  task automatic countTicks(input int n, input bit alt, output int ticks);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      mclkEn = alt ? (i % 2 == 0) : 1'b1;
      @(negedge clk);
      if (switchTick) ticks++;
    end
    mclkEn = 1'b0;
  endtask

  task automatic waitReady(output int cycles);
    cycles = 0;
    while (!ready && cycles < 1000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int ticks, cyc;
    repeat (3) @(negedge clk);
    check(ready == 0 && switchTick == 0, "R1 reset", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 0 && switchTick == 0, "R1 after reset", switchTick, 0);

    // R7: timeout path
    phaseTag = "R7";
    pwrDown = 1'b0;
    waitReady(cyc);
    check(cyc == T + 1, "R7 timeout length", cyc, T + 1);

    // R2: normal rate, dense and sparse enables
    phaseTag = "R2";
    countTicks(144, 1'b0, ticks);
    check(ticks == 36, "R2 dense enables", ticks, 36);
    countTicks(64, 1'b1, ticks);
    check(ticks == 8, "R2 sparse enables", ticks, 8);

    // R4: hop request while running is held back
    phaseTag = "R4";
    hopReq = 1'b1;
    countTicks(144, 1'b0, ticks);
    check(ticks == 36, "R4 hop ignored while up", ticks, 36);

    // R5: power-down stops ticks, drops ready
    phaseTag = "R5";
    pwrDown = 1'b1;
    countTicks(20, 1'b0, ticks);
    check(ticks == 0, "R5 no ticks while down", ticks, 0);
    check(ready == 0, "R5 ready low", ready, 0);

    // R10: relock-done pulse while down has no effect
    phaseTag = "R10";
    relockDone = 1'b1;
    @(negedge clk);
    relockDone = 1'b0;
    pwrDown = 1'b0;
    mclkEn = 1'b1;
    waitReady(cyc);
    check(cyc == T + 1, "R10 full wait after ignored pulse", cyc, T + 1);

    // R3: hop mode rate and pattern (R8: counting restarts at ready)
    phaseTag = "R3";
    countTicks(144, 1'b0, ticks);
    check(ticks == 16, "R3 hop tick count", ticks, 16);

    // R6: relock-done ends the wait early
    phaseTag = "R6";
    pwrDown = 1'b1;
    hopReq = 1'b0;
    repeat (3) @(negedge clk);
    pwrDown = 1'b0;
    mclkEn = 1'b1;
    repeat (5) @(negedge clk);
    check(ready == 0, "R6 still waiting", ready, 0);
    relockDone = 1'b1;
    @(negedge clk);
    relockDone = 1'b0;
    check(ready == 1, "R6 ready after relock-done", ready, 1);

    // R8: first tick exactly one base period after ready
    phaseTag = "R8";
    ticks = 0;
    cyc = 0;
    while (!switchTick && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == B, "R8 first tick delay", cyc, B);

    // R9: ready holds while powered up
    phaseTag = "R9";
    countTicks(100, 1'b0, ticks);
    check(ready == 1, "R9 ready held", ready, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule